// File: doc/BRIEF.md
# Alarm Status and Interrupt Register

This block gathers one-cycle event pulses from the receive overhead path into a byte of sticky status bits. The pulses report a new filtered transport-overhead value, a new filtered path-overhead value, transitions of three alarms (path yellow, far-end receive failure, protection-switch byte failure) and a performance-counter overflow. Any of these also sets a summary bit. The summary bit, qualified by an enable input, drives a registered interrupt line.

A simple synchronous processor bus reads the status through three addresses. The first returns the sticky byte and clears it. The second returns the same sticky byte and leaves it as it is; writing ones to this address clears the matching bits. The third returns the live alarm levels without any latching. Read data is registered and appears on the cycle after the read strobe.

Top module: `alarm_stat_regs`

## Requirements
- R1: After reset the sticky byte is 0x00, `rdata_o` is 0x00 and `irq_o` is 0.
- R2: A pulse on `toh_new_i` sets bit 6 and a pulse on `poh_new_i` sets bit 5. `alm_ev_i[2]`, `alm_ev_i[1]` and `alm_ev_i[0]` set bits 4, 3 and 2. Each set bit stays set until it is cleared.
- R3: Bit 7 is set by any event pulse, including `pm_ovf_i` alone.
- R4: Bits 1 and 0 read as 0 in every view.
- R5: A read at `COR_ADDR` (default 0x2) returns the sticky byte as it was before the read, and then clears all of its bits.
- R6: A read at `W1C_ADDR` (default 0x3) returns the sticky byte and does not change it.
- R7: A write at `W1C_ADDR` clears only the bits written as 1. Writing back a value just read clears the byte.
- R8: A read at `LIVE_ADDR` (default 0x5) returns `{3'b000, alm_lvl_i[2:0], 2'b00}`, sampled in the read cycle.
- R9: When a set event and a clear action hit the same bit in the same cycle, the bit ends up set.
- R10: `irq_o` is a register that loads sticky bit 7 ANDed with `irq_en_i`. It is 0 whenever `irq_en_i` was 0 in the previous cycle.
- R11: `rdata_o` loads only on a read strobe and holds otherwise. A read at any other address returns 0x00, and a write to any other address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| toh_new_i | input | 1 | New filtered transport-overhead value pulse |
| poh_new_i | input | 1 | New filtered path-overhead value pulse |
| alm_ev_i | input | 3 | Alarm transition pulses: [2] path yellow, [1] far-end failure, [0] protection bytes failure |
| pm_ovf_i | input | 1 | Performance counter overflow pulse |
| alm_lvl_i | input | 3 | Live alarm levels, same bit order as `alm_ev_i` |
| irq_en_i | input | 1 | Interrupt enable |
| addr_i | input | 4 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Registered interrupt output |

## Verification
A vector table fires each event source alone and then all of them together, with a different live-level pattern each time. Firing sources one at a time exposes swapped or missing bit positions. The live patterns differ from the latched contents, which separates the unlatched view from the sticky ones. Each vector is read through the non-clearing view, then the clearing view, then the non-clearing view again, which tells clear-on-read apart from read-only behaviour. Directed cases cover partial write-one-to-clear masks, a set and a clear hitting the same cycle, a disabled interrupt, unmapped addresses and the holding of read data.

// File: rtl/alarm_stat_pkg.sv
package alarm_stat_pkg;
  localparam int STAT_W  = 8;
  localparam int N_ALM   = 3;
  localparam int SUM_BIT = 7;
  localparam int TOH_BIT = 6;
  localparam int POH_BIT = 5;
  localparam int ALM_LSB = 2;
  localparam logic [STAT_W-1:0] USED_MASK = 8'hFC;
  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/stat_set_map.sv
module stat_set_map
  import alarm_stat_pkg::*;
(
  input  logic             toh_i,
  input  logic             poh_i,
  input  logic [N_ALM-1:0] alm_ev_i,
  input  logic             pm_ovf_i,
  output stat_t            set_o
);
  always_comb begin
    set_o          = '0;
    set_o[TOH_BIT] = toh_i;
    set_o[POH_BIT] = poh_i;
    for (int i = 0; i < N_ALM; i++) set_o[ALM_LSB+i] = alm_ev_i[i];
    set_o[SUM_BIT] = toh_i | poh_i | (|alm_ev_i) | pm_ovf_i;
  end
endmodule

// File: rtl/stat_sticky_bank.sv
module stat_sticky_bank #(
  parameter int          W    = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  // set term applied last: a same-cycle event beats a clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= ((q_o & ~clr_i) | set_i) & MASK;
  end

  // R2 R9
  set_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q_o & $past(set_i & MASK)) == $past(set_i & MASK)));

  // R7
  clr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0 && set_i == '0) |=> ((q_o & $past(clr_i)) == '0));
endmodule

// File: rtl/stat_read_port.sv
module stat_read_port
  import alarm_stat_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] COR_ADDR  = 'h2,
  parameter logic [ADDR_W-1:0] W1C_ADDR  = 'h3,
  parameter logic [ADDR_W-1:0] LIVE_ADDR = 'h5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  stat_t             wdata_i,
  input  stat_t             latched_i,
  input  stat_t             live_i,
  output stat_t             clr_o,
  output stat_t             rdata_o
);
  logic rd_cor, wr_w1c;
  assign rd_cor = rd_i && (addr_i == COR_ADDR);
  assign wr_w1c = wr_i && (addr_i == W1C_ADDR);

  always_comb begin
    clr_o = '0;
    if (rd_cor) clr_o = '1;
    if (wr_w1c) clr_o = clr_o | wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_i) begin
      case (addr_i)
        COR_ADDR, W1C_ADDR: rdata_o <= latched_i & USED_MASK;
        LIVE_ADDR:          rdata_o <= live_i & USED_MASK;
        default:            rdata_o <= '0;
      endcase
    end
  end

  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  // R5
  cor_returns_old_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cor |=> (rdata_o == $past(latched_i)));
endmodule

// File: rtl/stat_irq_reg.sv
module stat_irq_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sum_i,
  input  logic en_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= sum_i & en_i;
  end

  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_o);

  // R10
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sum_i) |=> irq_o);
endmodule

// File: rtl/alarm_stat_regs.sv
module alarm_stat_regs
  import alarm_stat_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] COR_ADDR  = 'h2,
  parameter logic [ADDR_W-1:0] W1C_ADDR  = 'h3,
  parameter logic [ADDR_W-1:0] LIVE_ADDR = 'h5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              toh_new_i,
  input  logic              poh_new_i,
  input  logic [2:0]        alm_ev_i,
  input  logic              pm_ovf_i,
  input  logic [2:0]        alm_lvl_i,
  input  logic              irq_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  stat_t set_vec, clr_vec, latched, live;

  always_comb begin
    live = '0;
    live[ALM_LSB +: N_ALM] = alm_lvl_i;
  end

  stat_set_map u_map (
    .toh_i    (toh_new_i),
    .poh_i    (poh_new_i),
    .alm_ev_i (alm_ev_i),
    .pm_ovf_i (pm_ovf_i),
    .set_o    (set_vec)
  );

  stat_sticky_bank #(.W(STAT_W), .MASK(USED_MASK)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .q_o    (latched)
  );

  stat_read_port #(
    .ADDR_W(ADDR_W), .COR_ADDR(COR_ADDR), .W1C_ADDR(W1C_ADDR), .LIVE_ADDR(LIVE_ADDR)
  ) u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .latched_i (latched),
    .live_i    (live),
    .clr_o     (clr_vec),
    .rdata_o   (rdata_o)
  );

  stat_irq_reg u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sum_i  (latched[SUM_BIT]),
    .en_i   (irq_en_i),
    .irq_o  (irq_o)
  );

  // R3
  summary_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (toh_new_i || poh_new_i || (|alm_ev_i) || pm_ovf_i) |=> latched[SUM_BIT]);

  // R5
  cor_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == COR_ADDR && set_vec == '0) |=> (latched == '0));

  // R6
  w1c_read_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == W1C_ADDR && !wr_i) |=> ((latched & $past(latched)) == $past(latched)));

  // R4
  low_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> (rdata_o[1:0] == 2'b00));
endmodule

// File: tb/sim_alarm_stat_regs.sv
module sim_alarm_stat_regs;
  localparam logic [3:0] A_COR = 4'h2, A_W1C = 4'h3, A_LIVE = 4'h5, A_NONE = 4'h7;

  logic clk = 0, rst_ni = 0;
  logic toh = 0, poh = 0, pm = 0, irq_en = 0, rd = 0, wr = 0;
  logic [2:0] alm_ev = 0, alm_lvl = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  alarm_stat_regs u0 (
    .clk_i(clk), .rst_ni(rst_ni), .toh_new_i(toh), .poh_new_i(poh),
    .alm_ev_i(alm_ev), .pm_ovf_i(pm), .alm_lvl_i(alm_lvl), .irq_en_i(irq_en),
    .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  // {stim[7]=pm [6]=toh [5]=poh [4:2]=alarm ev, lvl, exp latched, exp live}
  localparam logic [26:0] VEC [7] = '{
    {8'h40, 3'b000, 8'hC0, 8'h00},
    {8'h20, 3'b101, 8'hA0, 8'h14},
    {8'h10, 3'b100, 8'h90, 8'h10},
    {8'h08, 3'b010, 8'h88, 8'h08},
    {8'h04, 3'b001, 8'h84, 8'h04},
    {8'h80, 3'b111, 8'h80, 8'h1C},
    {8'hFC, 3'b000, 8'hFC, 8'h00}
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic pulse(input logic [7:0] s);
    @(negedge clk); pm = s[7]; toh = s[6]; poh = s[5]; alm_ev = s[4:2];
    @(negedge clk); pm = 0; toh = 0; poh = 0; alm_ev = 0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] d, hold;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rdata, 8'h00, "R1 rdata after reset");
    chk({7'b0, irq}, 8'h00, "R1 irq after reset");
    rst_ni = 1;
    rd_reg(A_W1C, d); chk(d, 8'h00, "R1 sticky after reset");

    irq_en = 1;
    for (int i = 0; i < 7; i++) begin
      logic [26:0] v;
      v = VEC[i];
      alm_lvl = v[18:16];
      pulse(v[26:19]);
      rd_reg(A_W1C, d);  chk(d, v[15:8], "R2 R3 latched bits");
      chk({6'b0, d[1:0]}, 8'h00, "R4 low bits");
      chk({7'b0, irq}, 8'h01, "R10 irq set");
      rd_reg(A_LIVE, d); chk(d, v[7:0], "R8 live view");
      rd_reg(A_W1C, d);  chk(d, v[15:8], "R6 no clear on read");
      rd_reg(A_COR, d);  chk(d, v[15:8], "R5 clear-on-read value");
      rd_reg(A_W1C, d);  chk(d, 8'h00, "R5 cleared after read");
      chk({7'b0, irq}, 8'h00, "R10 irq dropped");
    end

    // R10 disabled interrupt
    irq_en = 0;
    pulse(8'h40);
    repeat (2) @(negedge clk);
    chk({7'b0, irq}, 8'h00, "R10 irq gated");
    irq_en = 1;
    repeat (2) @(negedge clk);
    chk({7'b0, irq}, 8'h01, "R10 irq enabled");

    // R7 partial write-one-to-clear
    pulse(8'hFC);
    wr_reg(A_W1C, 8'h43);
    rd_reg(A_W1C, d); chk(d, 8'hBC, "R7 partial clear");
    wr_reg(A_W1C, d);
    rd_reg(A_W1C, d); chk(d, 8'h00, "R7 write-back clears");

    // R9 clear-on-read vs event in same cycle
    @(negedge clk); addr = A_COR; rd = 1; toh = 1;
    @(negedge clk); rd = 0; toh = 0; d = rdata;
    chk(d, 8'h00, "R9 read returns prior value");
    rd_reg(A_W1C, d); chk(d, 8'hC0, "R9 set wins over read clear");
    // R9 write clear vs event in same cycle
    @(negedge clk); addr = A_W1C; wdata = 8'hC0; wr = 1; toh = 1;
    @(negedge clk); wr = 0; toh = 0;
    rd_reg(A_W1C, d); chk(d, 8'hC0, "R9 set wins over write clear");

    // R11 unmapped access and read data hold
    wr_reg(A_NONE, 8'hFF);
    rd_reg(A_W1C, d); chk(d, 8'hC0, "R11 unmapped write ignored");
    hold = d;
    @(negedge clk); addr = A_LIVE; alm_lvl = 3'b111;
    repeat (2) @(negedge clk);
    chk(rdata, hold, "R11 rdata holds without read");
    rd_reg(A_NONE, d); chk(d, 8'h00, "R11 unmapped read zero");

    summary();
  end
endmodule